// File: doc/BRIEF.md
# Compressed-Instruction Fetch Aligner

This block sits between instruction fetch and a set of parallel decode lanes. Fetch delivers fixed-width words in which 16-bit compressed and 32-bit instructions are freely mixed. A 32-bit instruction may begin on any halfword, so it can start in one word and finish in the next. The aligner keeps the previously accepted word and a consumption pointer that spans the kept word and the word now offered. One scanner per halfword position classifies the instruction that would start there. A boundary chain then marks the real starts in program order, and one extractor per decode lane picks the oldest remaining complete instructions.

Each fetch word may carry a taken-prediction marker with the index of the last halfword that belongs to the fetch block. Halfwords after that index are discarded, and the word after it begins a fresh stream. If the marked halfword is the first half of a 32-bit instruction, the prediction was false. The aligner then emits everything older, drops the partial instruction and raises a redo request that carries its PC.

Top module: `ca_fetch_aligner`

## Requirements
- R1: The two low bits of a halfword give the length of the instruction starting there: 2'b11 means 32 bits, any other value means 16 bits. A 16-bit instruction is output zero-extended with its compressed flag set.
- R2: In each cycle the valid lanes form a contiguous group starting at lane 0. Lane 0 carries the oldest instruction, and the lanes in order follow program order with no instruction skipped or repeated.
- R3: Each output PC equals the PC of the word that holds the instruction's first halfword plus twice that halfword's index within the word.
- R4: A 32-bit instruction whose first half is the last halfword of a word is held back until the next word arrives. It is then emitted as {first halfword of new word, last halfword of old word}, with the old word's PC base.
- R5: The fetch input is accepted only when the decode lanes are ready and can take every complete instruction still pending in the offered word this cycle. Otherwise in_ready is low and the remainder is delivered over the following cycles.
- R6: When a word is accepted with the prediction marker set, halfwords after in_cut_slot are ignored. No instruction straddles from that word into the next, and the next word is decoded from its halfword 0.
- R7: When the halfword at in_cut_slot of a marked word starts a 32-bit instruction, that instruction is not emitted. In the cycle the word is accepted, redo_valid is high and redo_pc holds its PC, and all older instructions are still emitted.
- R8: While flush is high no lane is valid, the offered word is dropped, and any held-back first half of a straddling instruction is discarded.
- R9: Out of reset no lane and no redo is valid, and with decode ready the input is ready.
- R10: While decode is not ready and the offered word is held, the lane outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard the held word, pending halves and the offered word |
| in_valid | input | 1 | Fetch word offered |
| in_ready | output | 1 | Fetch word accepted when high together with in_valid |
| in_word | input | FETCH_W | Fetch word, halfword 0 in the low bits |
| in_pc | input | PC_W | PC of halfword 0 of the fetch word |
| in_cut | input | 1 | Fetch block ends inside this word because of a taken prediction |
| in_cut_slot | input | log2(FETCH_W/16) | Index of the last halfword of the block when in_cut is high |
| dec_ready | input | 1 | Decode lanes take every valid lane this cycle |
| lane_valid | output | LANES | Per-lane instruction valid |
| lane_insn | output | LANES*32 | Per-lane instruction, lane k at bits 32k and up |
| lane_pc | output | LANES*PC_W | Per-lane instruction PC |
| lane_rvc | output | LANES | Per-lane compressed flag |
| redo_valid | output | 1 | Refetch request for a truncated 32-bit instruction |
| redo_pc | output | PC_W | PC of the truncated instruction |

## Verification
The bench sends long streams of mixed lengths, so 32-bit instructions regularly start on the last halfword of a word. An aligner that joined the halves in the wrong order or used the new word's PC would then break the expected stream. A word of four compressed instructions on two lanes must hold in_ready low; a design that accepted it early would lose the last two. Marked words test both cases: the cut lands after a complete instruction, where a design that ignored the marker would emit stale tail halfwords or carry a half into the next block, and the cut lands on the first half of a 32-bit instruction, where a design would emit garbage instead of a redo. A flush with a pending first half, and random decode stalls, check that stale halves are not joined to fresh words and that stalled outputs hold.

// File: rtl/ca_pkg.sv
package ca_pkg;

   localparam int unsigned HW_BITS   = 16;
   localparam int unsigned INSN_BITS = 32;

   // Classification produced by one halfword scanner.
   typedef struct packed {
      logic wide;    // a 32-bit instruction starts here
      logic whole;   // every slice of that instruction is present
      logic redo;    // first half sits on a predicted block end
   } slot_info_t;

   function automatic logic is_wide(input logic [HW_BITS-1:0] h);
      return h[1:0] == 2'b11;
   endfunction

endpackage

// File: rtl/ca_scanner.sv
module ca_scanner
   import ca_pkg::*;
#(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned OFF_W = 2
)(
   input  logic [HW_BITS-1:0]   lo_hw,
   input  logic [HW_BITS-1:0]   hi_hw,
   input  logic                 lo_present,
   input  logic                 hi_present,
   input  logic                 at_cut,
   input  logic [PC_W-1:0]      base_pc,
   input  logic [OFF_W-1:0]     off,
   output slot_info_t           info,
   output logic [INSN_BITS-1:0] insn,
   output logic [PC_W-1:0]      pc
);

   logic wide;

   assign wide       = is_wide(lo_hw);
   assign info.wide  = wide;
   assign info.whole = lo_present & (~wide | hi_present);
   assign info.redo  = lo_present & wide & at_cut;
   assign insn       = wide ? {hi_hw, lo_hw} : {{HW_BITS{1'b0}}, lo_hw};
   assign pc         = base_pc + PC_W'({off, 1'b0});

endmodule

// File: rtl/ca_chain.sv
module ca_chain #(
   parameter int unsigned N     = 8,
   parameter int unsigned LANES = 2,
   parameter int unsigned IDX_W = 4
)(
   input  logic [IDX_W-1:0]            pos,
   input  logic [N-1:0]                wide,
   input  logic [N-1:0]                whole,
   input  logic [N-1:0]                redo,
   output logic [LANES-1:0][N-1:0]     sel,
   output logic [IDX_W-1:0]            cnt,
   output logic [IDX_W-1:0]            end_pos,
   output logic                        hit,
   output logic [N-1:0]                hit_sel
);

   // Boundary walk in program order from the consumption pointer.
   always_comb begin
      logic        r1, w1, r2, w2, cur, blocked;
      int unsigned cnt_v;
      r1 = 1'b0; w1 = 1'b0; r2 = 1'b0; w2 = 1'b0;
      blocked = 1'b0;
      cnt_v   = 0;
      sel     = '0;
      end_pos = pos;
      hit     = 1'b0;
      hit_sel = '0;
      for (int i = 0; i < int'(N); i++) begin
         cur = (IDX_W'(i) == pos) | (r1 & ~w1) | (r2 & w2);
         if (cur && !blocked) begin
            if (whole[i]) begin
               for (int k = 0; k < int'(LANES); k++) begin
                  if (cnt_v == k) begin
                     sel[k][i] = 1'b1;
                     end_pos   = IDX_W'(i + (wide[i] ? 2 : 1));
                  end
               end
               cnt_v = cnt_v + 1;
            end else begin
               blocked    = 1'b1;
               hit        = redo[i];
               hit_sel[i] = redo[i];
            end
         end
         r2 = r1; w2 = w1;
         r1 = cur; w1 = wide[i];
      end
      cnt = IDX_W'(cnt_v);
   end

endmodule

// File: rtl/ca_extractor.sv
module ca_extractor
   import ca_pkg::*;
#(
   parameter int unsigned N    = 8,
   parameter int unsigned PC_W = 32
)(
   input  logic [N-1:0]           sel,
   input  logic [N*INSN_BITS-1:0] insn_all,
   input  logic [N*PC_W-1:0]      pc_all,
   input  logic [N-1:0]           wide,
   output logic [INSN_BITS-1:0]   insn,
   output logic [PC_W-1:0]        pc,
   output logic                   rvc
);

   always_comb begin
      insn = '0;
      pc   = '0;
      rvc  = 1'b0;
      for (int i = 0; i < int'(N); i++) begin
         if (sel[i]) begin
            insn = insn | insn_all[i*INSN_BITS +: INSN_BITS];
            pc   = pc   | pc_all[i*PC_W +: PC_W];
            rvc  = rvc  | ~wide[i];
         end
      end
   end

endmodule

// File: rtl/ca_fetch_aligner.sv
module ca_fetch_aligner
   import ca_pkg::*;
#(
   parameter int unsigned FETCH_W = 64,
   parameter int unsigned LANES   = 2,
   parameter int unsigned PC_W    = 32
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic [FETCH_W-1:0]            in_word,
   input  logic [PC_W-1:0]               in_pc,
   input  logic                          in_cut,
   input  logic [$clog2(FETCH_W/16)-1:0] in_cut_slot,
   input  logic                          dec_ready,
   output logic [LANES-1:0]              lane_valid,
   output logic [LANES*32-1:0]           lane_insn,
   output logic [LANES*PC_W-1:0]         lane_pc,
   output logic [LANES-1:0]              lane_rvc,
   output logic                          redo_valid,
   output logic [PC_W-1:0]               redo_pc
);

   localparam int unsigned H     = FETCH_W / HW_BITS;
   localparam int unsigned N     = 2 * H;
   localparam int unsigned IDX_W = $clog2(N + 1);
   localparam int unsigned OFF_W = $clog2(H);
   localparam logic [IDX_W-1:0] HOME = IDX_W'(H);

   generate
      if (FETCH_W % HW_BITS != 0 || H < 2) begin : g_bad_fetch_w
         $error("FETCH_W must be a multiple of 16 holding at least two halfwords");
      end
      if (LANES < 1 || LANES > N) begin : g_bad_lanes
         $error("LANES must lie between 1 and the scanner count");
      end
   endgenerate

   // Held word and consumption pointer over {offered word, held word}.
   logic [FETCH_W-1:0] buf_word;
   logic [PC_W-1:0]    buf_pc;
   logic [IDX_W-1:0]   pos;

   logic [(N+1)*HW_BITS-1:0] hw_ext;
   logic [N:0]               present;
   logic [N-1:0]             at_cut;

   assign hw_ext = {{HW_BITS{1'b0}}, in_word, buf_word};

   always_comb begin
      present = '0;
      at_cut  = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (i < int'(H)) begin
            present[i] = 1'b1;
         end else begin
            present[i] = in_valid & (~in_cut | (OFF_W'(i - int'(H)) <= in_cut_slot));
            at_cut[i]  = in_valid & in_cut & (OFF_W'(i - int'(H)) == in_cut_slot);
         end
      end
   end

   // One scanner per halfword position.
   logic [N-1:0]           wide, whole, redo_bit;
   logic [N*INSN_BITS-1:0] insn_all;
   logic [N*PC_W-1:0]      pc_all;

   for (genvar g = 0; g < int'(N); g++) begin : g_scan
      slot_info_t info;
      ca_scanner #(.PC_W(PC_W), .OFF_W(OFF_W)) u_scan (
         .lo_hw     (hw_ext[g*HW_BITS +: HW_BITS]),
         .hi_hw     (hw_ext[(g+1)*HW_BITS +: HW_BITS]),
         .lo_present(present[g]),
         .hi_present(present[g+1]),
         .at_cut    (at_cut[g]),
         .base_pc   ((g < int'(H)) ? buf_pc : in_pc),
         .off       (OFF_W'(g % int'(H))),
         .info      (info),
         .insn      (insn_all[g*INSN_BITS +: INSN_BITS]),
         .pc        (pc_all[g*PC_W +: PC_W])
      );
      assign wide[g]     = info.wide;
      assign whole[g]    = info.whole;
      assign redo_bit[g] = info.redo;
   end

   logic [LANES-1:0][N-1:0] sel;
   logic [IDX_W-1:0]        cnt, end_pos;
   logic                    hit;
   logic [N-1:0]            hit_sel;

   ca_chain #(.N(N), .LANES(LANES), .IDX_W(IDX_W)) u_chain (
      .pos    (pos),
      .wide   (wide),
      .whole  (whole),
      .redo   (redo_bit),
      .sel    (sel),
      .cnt    (cnt),
      .end_pos(end_pos),
      .hit    (hit),
      .hit_sel(hit_sel)
   );

   for (genvar k = 0; k < int'(LANES); k++) begin : g_lane
      ca_extractor #(.N(N), .PC_W(PC_W)) u_ext (
         .sel     (sel[k]),
         .insn_all(insn_all),
         .pc_all  (pc_all),
         .wide    (wide),
         .insn    (lane_insn[k*INSN_BITS +: INSN_BITS]),
         .pc      (lane_pc[k*PC_W +: PC_W]),
         .rvc     (lane_rvc[k])
      );
      assign lane_valid[k] = ~flush & (cnt > IDX_W'(k));
   end

   logic room, accept;
   assign room       = cnt <= IDX_W'(LANES);
   assign in_ready   = flush | (dec_ready & room);
   assign accept     = in_valid & in_ready & ~flush;
   assign redo_valid = accept & hit;

   always_comb begin
      redo_pc = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (hit_sel[i]) redo_pc = redo_pc | pc_all[i*PC_W +: PC_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos      <= HOME;
         buf_word <= '0;
         buf_pc   <= '0;
      end else if (flush) begin
         pos <= HOME;
      end else if (accept) begin
         buf_word <= in_word;
         buf_pc   <= in_pc;
         pos      <= (in_cut || end_pos < HOME) ? HOME : end_pos - HOME;
      end else if (dec_ready) begin
         pos <= end_pos;
      end
   end

   // ---------------- assertions ----------------
   for (genvar k = 1; k < int'(LANES); k++) begin : g_lane_chk
      a_r2_lane_fill: assert property (@(posedge clk) disable iff (!rst_n)
         lane_valid[k] |-> lane_valid[k-1]);
      a_r2_lane_pc_order: assert property (@(posedge clk) disable iff (!rst_n)
         lane_valid[k] |-> lane_pc[k*PC_W +: PC_W] > lane_pc[(k-1)*PC_W +: PC_W]);
   end

   for (genvar k = 0; k < int'(LANES); k++) begin : g_rvc_chk
      a_r1_rvc_zero_upper: assert property (@(posedge clk) disable iff (!rst_n)
         lane_valid[k] && lane_rvc[k] |-> lane_insn[k*INSN_BITS+16 +: 16] == 16'h0);
   end

   a_r5_accept_needs_decode: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !flush |-> dec_ready);

   a_r6_cut_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      accept && in_cut |=> pos == HOME);

   a_r7_redo_on_cut_accept: assert property (@(posedge clk) disable iff (!rst_n)
      redo_valid |-> in_valid && in_cut && in_ready);

   a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      flush ##1 !in_valid |-> lane_valid == '0);

   a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !dec_ready && !flush ##1 in_valid && !flush |-> $stable(lane_insn));

endmodule

// File: tb/test_ca_fetch_aligner.sv
module test_ca_fetch_aligner;

   localparam int FW = 64;
   localparam int LN = 2;
   localparam int PW = 32;
   localparam int H  = FW / 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              flush = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [FW-1:0]     in_word = '0;
   logic [PW-1:0]     in_pc = '0;
   logic              in_cut = 1'b0;
   logic [1:0]        in_cut_slot = '0;
   logic              dec_ready = 1'b1;
   logic [LN-1:0]     lane_valid;
   logic [LN*32-1:0]  lane_insn;
   logic [LN*PW-1:0]  lane_pc;
   logic [LN-1:0]     lane_rvc;
   logic              redo_valid;
   logic [PW-1:0]     redo_pc;

   always #10 clk = ~clk;   // 50 MHz

   ca_fetch_aligner #(.FETCH_W(FW), .LANES(LN), .PC_W(PW)) i_ca_fetch_aligner (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_pc(in_pc),
      .in_cut(in_cut), .in_cut_slot(in_cut_slot), .dec_ready(dec_ready),
      .lane_valid(lane_valid), .lane_insn(lane_insn), .lane_pc(lane_pc),
      .lane_rvc(lane_rvc), .redo_valid(redo_valid), .redo_pc(redo_pc)
   );

   typedef struct packed {
      logic          redo;
      logic [31:0]   insn;
      logic [PW-1:0] pc;
   } exp_t;

   exp_t q[$];
   int   compared = 0;
   int   mismatched = 0;
   bit   done = 1'b0;
   bit   stall_en = 1'b0;
   logic [31:0] seed = 32'h1ACE_B00C;
   logic [31:0] seed2 = 32'h0BAD_5EED;

   function automatic logic [31:0] rnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic push_insn(input logic [31:0] insn, input logic [PW-1:0] pc);
      exp_t e;
      e.redo = 1'b0; e.insn = insn; e.pc = pc;
      q.push_back(e);
   endtask

   task automatic push_redo(input logic [PW-1:0] pc);
      exp_t e;
      e.redo = 1'b1; e.insn = '0; e.pc = pc;
      q.push_back(e);
   endtask

   // Driver: offer one word and hold it until accepted.
   task automatic send_word(input logic [FW-1:0] w, input logic [PW-1:0] pc,
                            input bit cut, input logic [1:0] slot);
      in_valid = 1'b1; in_word = w; in_pc = pc; in_cut = cut; in_cut_slot = slot;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      in_valid = 1'b0; in_cut = 1'b0;
   endtask

   // Random instruction stream packed into nwords words; mode 0 mixed,
   // mode 1 only compressed, mode 2 one compressed then only 32-bit.
   task automatic run_stream(input logic [PW-1:0] base, input int nwords, input int mode);
      logic [15:0]   hws[$];
      logic [PW-1:0] pc;
      logic [31:0]   r;
      logic [15:0]   lo;
      logic [FW-1:0] w;
      bit            wd;
      int            total;
      total = nwords * H;
      pc = base;
      while (hws.size() < total) begin
         r = rnd();
         if (mode == 1) wd = 1'b0;
         else if (mode == 2) wd = (hws.size() != 0);
         else wd = r[0];
         if (hws.size() == total - 1) wd = 1'b0;
         if (wd) begin
            lo = {r[15:2], 2'b11};
            hws.push_back(lo);
            hws.push_back(r[31:16]);
            push_insn({r[31:16], lo}, pc);
            pc = pc + 4;
         end else begin
            lo = {r[15:2], (r[1:0] == 2'b11) ? 2'b10 : r[1:0]};
            hws.push_back(lo);
            push_insn({16'h0, lo}, pc);
            pc = pc + 2;
         end
      end
      for (int wi = 0; wi < nwords; wi++) begin
         for (int j = 0; j < H; j++) w[j*16 +: 16] = hws[wi*H + j];
         send_word(w, base + PW'(wi * 2 * H), 1'b0, 2'd0);
      end
   endtask

   task automatic drain();
      for (int i = 0; i < 200 && q.size() != 0; i++) @(posedge clk);
      @(posedge clk); #1;
   endtask

   // Decode stall pattern.
   always @(posedge clk) begin
      #1;
      if (stall_en) begin
         seed2 = seed2 ^ (seed2 << 13);
         seed2 = seed2 ^ (seed2 >> 17);
         seed2 = seed2 ^ (seed2 << 5);
         dec_ready = (seed2[1:0] != 2'b00);
      end else begin
         dec_ready = 1'b1;
      end
   end

   // Monitor: pops the scoreboard as lanes and redo fire.
   logic          prev_hold = 1'b0;
   logic [LN-1:0] prev_valid;
   logic [LN*32-1:0] prev_insn;

   always @(negedge clk) begin
      if (rst_n && !flush && !done) begin
         if (prev_hold && in_valid) begin
            check(lane_valid == prev_valid, "R10 stalled lane_valid", 64'(lane_valid), 64'(prev_valid));
            check(lane_insn == prev_insn, "R10 stalled lane_insn", 64'(lane_insn), 64'(prev_insn));
         end
         for (int k = 0; k < LN; k++) begin
            if (lane_valid[k] && dec_ready) begin
               if (q.size() == 0) begin
                  check(1'b0, "R2 unexpected lane output", 64'(lane_insn[k*32 +: 32]), 64'h0);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  check(!e.redo, "R7 lane output where redo expected", 64'(lane_pc[k*PW +: PW]), 64'(e.pc));
                  check(lane_insn[k*32 +: 32] == e.insn, "R4 lane insn", 64'(lane_insn[k*32 +: 32]), 64'(e.insn));
                  check(lane_pc[k*PW +: PW] == e.pc, "R3 lane pc", 64'(lane_pc[k*PW +: PW]), 64'(e.pc));
                  check(lane_rvc[k] == (e.insn[1:0] != 2'b11), "R1 compressed flag",
                        64'(lane_rvc[k]), 64'(e.insn[1:0] != 2'b11));
               end
            end
         end
         if (redo_valid) begin
            if (q.size() == 0) begin
               check(1'b0, "R7 unexpected redo", 64'(redo_pc), 64'h0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(e.redo, "R7 redo where instruction expected", 64'(redo_pc), 64'(e.pc));
               check(redo_pc == e.pc, "R7 redo pc", 64'(redo_pc), 64'(e.pc));
            end
         end
         prev_hold  = in_valid && !dec_ready;
         prev_valid = lane_valid;
         prev_insn  = lane_insn;
      end else begin
         prev_hold = 1'b0;
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         mismatched++;
         $display("FAIL R2 watchdog expired: actual %0d pending expected 0", q.size());
         summary();
         $finish;
      end
   end

   initial begin
      logic [FW-1:0] w;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R9: reset state
      @(negedge clk);
      check(lane_valid == '0, "R9 lanes after reset", 64'(lane_valid), 64'h0);
      check(!redo_valid, "R9 redo after reset", 64'(redo_valid), 64'h0);
      check(in_ready, "R9 ready after reset", 64'(in_ready), 64'h1);
      @(posedge clk); #1;

      // R5: four compressed instructions on two lanes
      w = {16'h4009, 16'h4005, 16'h4001, 16'h0051};
      push_insn(32'h0051, 32'h1000); push_insn(32'h4001, 32'h1002);
      push_insn(32'h4005, 32'h1004); push_insn(32'h4009, 32'h1006);
      in_valid = 1'b1; in_word = w; in_pc = 32'h1000; in_cut = 1'b0;
      @(negedge clk);
      check(!in_ready, "R5 ready low while lanes overflow", 64'(in_ready), 64'h0);
      check(lane_valid == 2'b11, "R2 both lanes filled", 64'(lane_valid), 64'h3);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1 in_valid = 1'b0;
      drain();

      // R4 R3 R1: mixed streams with straddles
      run_stream(32'h2000, 12, 0);
      run_stream(32'h3000, 6, 2);
      run_stream(32'h3800, 4, 1);
      drain();

      // R10: the same under decode stalls
      stall_en = 1'b1;
      run_stream(32'h4000, 16, 0);
      run_stream(32'h5000, 6, 2);
      drain();
      stall_en = 1'b0;
      @(posedge clk); #1;

      // R6: cut after a whole instruction, tail ignored, next word fresh
      w = {16'h1233, 16'h2221, 16'h3331, 16'h4441};
      push_insn(32'h4441, 32'h6000); push_insn(32'h3331, 32'h6002);
      send_word(w, 32'h6000, 1'b1, 2'd1);
      w = {16'h8889, 16'h7775, 16'h6665, 16'h5555};
      push_insn(32'h5555, 32'h7000); push_insn(32'h6665, 32'h7002);
      push_insn(32'h7775, 32'h7004); push_insn(32'h8889, 32'h7006);
      send_word(w, 32'h7000, 1'b0, 2'd0);
      drain();

      // R7: cut lands on the first half of a 32-bit instruction
      w = {16'hAAA1, 16'hBBB1, 16'hC0C3, 16'hD0D1};
      push_insn(32'hD0D1, 32'h8000); push_redo(32'h8002);
      send_word(w, 32'h8000, 1'b1, 2'd1);
      w = {16'h0121, 16'h0235, 16'h0349, 16'h045D};
      push_insn(32'h045D, 32'h9000); push_insn(32'h0349, 32'h9002);
      push_insn(32'h0235, 32'h9004); push_insn(32'h0121, 32'h9006);
      send_word(w, 32'h9000, 1'b0, 2'd0);
      drain();
      check(q.size() == 0, "R7 scoreboard empty after redo", 64'(q.size()), 64'h0);

      // R4 R8: pending first half held, then discarded by flush
      w = {16'hE0E3, 16'h0F09, 16'h0E05, 16'h0D01};
      push_insn(32'h0D01, 32'hA000); push_insn(32'h0E05, 32'hA002);
      push_insn(32'h0F09, 32'hA004);
      send_word(w, 32'hA000, 1'b0, 2'd0);
      drain();
      repeat (2) begin
         @(negedge clk);
         check(lane_valid == '0, "R4 half instruction held back", 64'(lane_valid), 64'h0);
      end
      @(posedge clk); #1 flush = 1'b1;
      @(negedge clk);
      check(lane_valid == '0, "R8 lanes quiet during flush", 64'(lane_valid), 64'h0);
      @(posedge clk); #1 flush = 1'b0;
      w = {16'h1119, 16'h2225, 16'h3331, 16'h444D};
      push_insn(32'h444D, 32'hB000); push_insn(32'h3331, 32'hB002);
      push_insn(32'h2225, 32'hB004); push_insn(32'h1119, 32'hB006);
      send_word(w, 32'hB000, 1'b0, 2'd0);
      drain();

      check(q.size() == 0, "R2 every expected item emitted", 64'(q.size()), 64'h0);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule